// File: doc/BRIEF.md
# DRAM Command Decoder with Mode Registers

This block sits on the device side of a double-data-rate DRAM command bus. On each rising clock edge it samples clock enable, the four active-low command strobes (chip select, row strobe, column strobe, write enable), the bank address and the row/column address. It recognises the two register-write commands and keeps the settings that the rest of the device needs: burst length, addressing order, read latency code, DLL reset, DLL enable and output driver code.

A register write is taken only when every bank reports idle. It is also refused when a field that must be zero is set, or when it names a reserved burst length. After every accepted write the decoder holds a short busy window in which any real command is refused. A refused command leaves every setting as it was and raises a one-cycle illegal flag. Bank state is supplied from outside as a per-bank idle vector. Refresh and data movement live elsewhere.

Top module: `ddrModeDec`

## Requirements
- R1: After reset the outputs read burst length 2 (`burstLen`=2), sequential order (`interleave`=0), latency code 0, DLL reset 0, DLL off (`dllOn`=0), driver code 00 and `illegalCmd`=0.
- R2: A cycle with `csN` high or `cke` low is ignored. No setting changes and `illegalCmd` stays low in the following cycle.
- R3: A cycle with `cke` high, `csN`, `rasN`, `casN` and `weN` all low, `bankAddr[0]`=0, all banks idle and the bank window free writes the mode register. `addr[2:0]` is the burst code, and 001/010/011 give `burstLen` 2/4/8. `addr[3]` is `interleave`, `addr[6:4]` is `readLatency` and `addr[8]` is `dllReset`. The new values appear after that clock edge.
- R4: The same command with `bankAddr[0]`=1 writes the extended register. `addr[0]`=0 sets `dllOn`=1 and `addr[0]`=1 clears it. `drvCode` takes `{addr[6],addr[1]}`.
- R5: A mode-register write is refused if any of `addr[7]`, `addr[11:9]` or `bankAddr[1]` is set.
- R6: A mode-register write whose burst code is not 001, 010 or 011 is refused.
- R7: An extended-register write is refused if any of `addr[5:2]`, `addr[11:7]` or `bankAddr[1]` is set, or if `{addr[6],addr[1]}` is not 01.
- R8: A register write is refused when any bit of `bankIdle` is low.
- R9: In the cycle after an accepted register write, any command other than a NOP (`rasN`,`casN`,`weN` all high) is refused. A NOP there is not flagged. A refused command does not restart the window, and commands two cycles after the write are taken normally.
- R10: A refused command leaves every setting unchanged and drives `illegalCmd` high for exactly the next cycle.
- R11: Any other command (not a register write) outside the busy window has no effect on the settings and is not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples all inputs |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low ignores the command |
| csN | input | 1 | Active-low chip select |
| rasN | input | 1 | Active-low row strobe |
| casN | input | 1 | Active-low column strobe |
| weN | input | 1 | Active-low write enable |
| bankAddr | input | 2 | Bank address; bit 0 selects the target register |
| addr | input | 12 | Address bus carrying the register fields |
| bankIdle | input | 4 | One bit per bank, high when that bank is precharged |
| burstLen | output | 4 | Burst length in beats (2, 4 or 8) |
| interleave | output | 1 | High for interleaved burst order |
| readLatency | output | 3 | Stored read latency code |
| dllReset | output | 1 | Stored DLL reset bit |
| dllOn | output | 1 | High when the DLL is enabled |
| drvCode | output | 2 | Stored driver strength code |
| illegalCmd | output | 1 | One-cycle pulse after a refused command |

## Verification
The busy window and the write-legality checks (bank idle, must-be-zero fields, burst code) can apply to the same cycle. This happens when a second register write arrives right after an accepted one, while a bank is open or a reserved field is set. The bench sends exactly that, and a behavioural reference model running beside the design must then agree on three points: a single flag pulse, unchanged settings, and no restart of the window. After that, a clean write in the very next cycle must be accepted. A long stretch of random commands, biased toward legal register writes, is compared against the model on every clock.

// File: rtl/ddrModeDecPkg.sv
package ddrModeDecPkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_NOP   = 2'd1,
    CMD_REGWR = 2'd2,
    CMD_OTHER = 2'd3
  } cmdKind_t;

  typedef struct packed {
    logic loadMode;
    logic loadExt;
    logic flagIllegal;
  } regStrobe_t;

  typedef struct packed {
    logic [2:0] blCode;
    logic       interleave;
    logic [2:0] latency;
    logic       dllReset;
    logic       dllOn;
    logic [1:0] drvCode;
  } modeFields_t;

  localparam logic [2:0] BL_CODE_MIN = 3'd1;
  localparam logic [2:0] BL_CODE_MAX = 3'd3;

endpackage

// File: rtl/ddrModeCtrl.sv
module ddrModeCtrl
  import ddrModeDecPkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BANK_W     = 2,
  parameter int NUM_BANKS  = 4,
  parameter int MRD_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bankIdle,
  output regStrobe_t           strobe
);

  localparam int CNT_W = $clog2(MRD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MRD_CYCLES - 1);
  // bits allowed to be set in each register write; every other bit must be zero
  localparam logic [ADDR_W-1:0] MODE_FREE = ADDR_W'(12'h17F);
  localparam logic [ADDR_W-1:0] EXT_FREE  = ADDR_W'(12'h043);

  cmdKind_t         kind;
  logic [CNT_W-1:0] busyCnt;
  logic             busy;
  logic             allIdle;
  logic             upperBankSet;
  logic             modeBad;
  logic             extBad;
  logic             blCodeOk;

  always_comb begin
    if (!cke || csN)                 kind = CMD_NONE;
    else if (rasN && casN && weN)    kind = CMD_NOP;
    else if (!rasN && !casN && !weN) kind = CMD_REGWR;
    else                             kind = CMD_OTHER;
  end

  assign busy         = (busyCnt != '0);
  assign allIdle      = &bankIdle;
  assign upperBankSet = |bankAddr[BANK_W-1:1];
  assign blCodeOk     = (addr[2:0] >= BL_CODE_MIN) && (addr[2:0] <= BL_CODE_MAX);
  assign modeBad      = upperBankSet || (|(addr & ~MODE_FREE)) || !blCodeOk;
  assign extBad       = upperBankSet || (|(addr & ~EXT_FREE)) ||
                        ({addr[6], addr[1]} != 2'b01);

  always_comb begin
    strobe = '0;
    if ((kind == CMD_REGWR || kind == CMD_OTHER) && busy) begin
      strobe.flagIllegal = 1'b1;
    end else if (kind == CMD_REGWR) begin
      if (!allIdle)          strobe.flagIllegal = 1'b1;
      else if (bankAddr[0]) begin
        if (extBad)          strobe.flagIllegal = 1'b1;
        else                 strobe.loadExt     = 1'b1;
      end else begin
        if (modeBad)         strobe.flagIllegal = 1'b1;
        else                 strobe.loadMode    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  busyCnt <= '0;
    else if (strobe.loadMode || strobe.loadExt) busyCnt <= CNT_LOAD;
    else if (busy)                              busyCnt <= busyCnt - 1'b1;
  end

  // R9: no register load directly after an accepted one
  a_r9_busy_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadMode || strobe.loadExt) |=> !(strobe.loadMode || strobe.loadExt));

  // R8: an open bank blocks every register load
  a_r8_banks_open: assert property (@(posedge clk) disable iff (!rstN)
    !(&bankIdle) |-> !(strobe.loadMode || strobe.loadExt));

  // R2: a deselected cycle produces no strobe
  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (csN || !cke) |-> (strobe == '0));

  // R10: at most one outcome per command
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadMode, strobe.loadExt, strobe.flagIllegal}));

endmodule

// File: rtl/ddrModeRegs.sv
module ddrModeRegs
  import ddrModeDecPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  regStrobe_t  strobe,
  input  logic [8:0]  fieldIn,
  output logic [3:0]  burstLen,
  output logic        interleave,
  output logic [2:0]  readLatency,
  output logic        dllReset,
  output logic        dllOn,
  output logic [1:0]  drvCode,
  output logic        illegalCmd
);

  modeFields_t fields;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fields         <= '0;
      fields.blCode  <= BL_CODE_MIN;
      illegalCmd     <= 1'b0;
    end else begin
      illegalCmd <= strobe.flagIllegal;
      if (strobe.loadMode) begin
        fields.blCode     <= fieldIn[2:0];
        fields.interleave <= fieldIn[3];
        fields.latency    <= fieldIn[6:4];
        fields.dllReset   <= fieldIn[8];
      end
      if (strobe.loadExt) begin
        fields.dllOn   <= !fieldIn[0];
        fields.drvCode <= {fieldIn[6], fieldIn[1]};
      end
    end
  end

  assign burstLen    = 4'd1 << fields.blCode;
  assign interleave  = fields.interleave;
  assign readLatency = fields.latency;
  assign dllReset    = fields.dllReset;
  assign dllOn       = fields.dllOn;
  assign drvCode     = fields.drvCode;

  // R6: only lengths 2, 4 and 8 are ever presented
  a_r6_bl_legal: assert property (@(posedge clk) disable iff (!rstN)
    (burstLen == 4'd2) || (burstLen == 4'd4) || (burstLen == 4'd8));

  // R10: a refusal pulses the flag and keeps every setting
  a_r10_refuse_holds: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagIllegal |=> (illegalCmd && $stable(fields)));

endmodule

// File: rtl/ddrModeDec.sv
module ddrModeDec
  import ddrModeDecPkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BANK_W     = 2,
  parameter int NUM_BANKS  = 4,
  parameter int MRD_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bankIdle,
  output logic [3:0]           burstLen,
  output logic                 interleave,
  output logic [2:0]           readLatency,
  output logic                 dllReset,
  output logic                 dllOn,
  output logic [1:0]           drvCode,
  output logic                 illegalCmd
);

  regStrobe_t strobe;

  ddrModeCtrl #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .MRD_CYCLES(MRD_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .addr(addr), .bankIdle(bankIdle),
    .strobe(strobe)
  );

  ddrModeRegs regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fieldIn(addr[8:0]),
    .burstLen(burstLen), .interleave(interleave), .readLatency(readLatency),
    .dllReset(dllReset), .dllOn(dllOn), .drvCode(drvCode), .illegalCmd(illegalCmd)
  );

  // R2: deselected cycles change nothing and raise no flag
  a_r2_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (csN || !cke) |=> ($stable({burstLen, interleave, readLatency, dllReset, dllOn, drvCode})
                       && !illegalCmd));

endmodule

// File: tb/ddrModeDec_tb_top.sv
module ddrModeDec_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cke = 1'b0, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  bankAddr = '0;
  logic [11:0] addr = '0;
  logic [3:0]  bankIdle = 4'hF;
  logic [3:0]  burstLen;
  logic        interleave, dllReset, dllOn, illegalCmd;
  logic [2:0]  readLatency;
  logic [1:0]  drvCode;

  int checks = 0, errors = 0;
  bit finished = 0;
  string curTag = "R1";

  always #5 clk = ~clk;

  ddrModeDec dut_i (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .addr(addr), .bankIdle(bankIdle),
    .burstLen(burstLen), .interleave(interleave), .readLatency(readLatency),
    .dllReset(dllReset), .dllOn(dllOn), .drvCode(drvCode), .illegalCmd(illegalCmd)
  );

  // behavioural reference model
  int   mLen, mLat, busyLeft;
  logic mIl, mDllR, mDllOn, mIll;
  logic [1:0] mDrv;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLen = 2; mIl = 0; mLat = 0; mDllR = 0; mDllOn = 0; mDrv = 0; mIll = 0; busyLeft = 0;
    end else begin
      bit sel, nop, wr, bad, took;
      sel  = cke && !csN;
      nop  = rasN && casN && weN;
      wr   = sel && !rasN && !casN && !weN;
      bad  = 0; took = 0;
      if (sel && !nop && busyLeft > 0) bad = 1;
      else if (wr) begin
        if (bankIdle != 4'hF) bad = 1;
        else if (!bankAddr[0]) begin
          if (addr[7] || addr[9] || addr[10] || addr[11] || bankAddr[1] ||
              addr[2:0] == 0 || addr[2:0] > 3) bad = 1;
          else begin
            mLen = 1 << addr[2:0]; mIl = addr[3]; mLat = addr[6:4]; mDllR = addr[8]; took = 1;
          end
        end else begin
          if (addr[2] || addr[3] || addr[4] || addr[5] || addr[7] || addr[8] || addr[9] ||
              addr[10] || addr[11] || bankAddr[1] || addr[6] || !addr[1]) bad = 1;
          else begin
            mDllOn = !addr[0]; mDrv = {addr[6], addr[1]}; took = 1;
          end
        end
      end
      if (busyLeft > 0) busyLeft = busyLeft - 1;
      if (took) busyLeft = 1;
      mIll = bad;
    end
  end

  task automatic compareOut();
    logic [12:0] act, exp;
    act = {burstLen, interleave, readLatency, dllReset, dllOn, drvCode, illegalCmd};
    exp = {4'(mLen), mIl, 3'(mLat), mDllR, mDllOn, mDrv, mIll};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual len=%0d il=%0b lat=%0d dllr=%0b dll=%0b drv=%0b ill=%0b expected len=%0d il=%0b lat=%0d dllr=%0b dll=%0b drv=%0b ill=%0b",
               curTag, act[12:9], act[8], act[7:5], act[4], act[3], act[2:1], act[0],
               exp[12:9], exp[8], exp[7:5], exp[4], exp[3], exp[2:1], exp[0]);
    end
  endtask

  // compare the previous cycle's result, then drive the next command
  task automatic step(input string tag, input logic k, input logic c, input logic r,
                      input logic ca, input logic w, input logic [1:0] ba,
                      input logic [11:0] a, input logic [3:0] idle);
    @(negedge clk);
    compareOut();
    curTag = tag;
    cke = k; csN = c; rasN = r; casN = ca; weN = w; bankAddr = ba; addr = a; bankIdle = idle;
  endtask

  task automatic nop(input string tag);
    step(tag, 1, 0, 1, 1, 1, 2'b00, 12'h000, 4'hF);
  endtask
  task automatic regWr(input string tag, input logic [1:0] ba, input logic [11:0] a,
                       input logic [3:0] idle);
    step(tag, 1, 0, 0, 0, 0, ba, a, idle);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nop("R1");
    nop("R1");
    // R3: BL4, interleaved, latency 3
    regWr("R3", 2'b00, 12'h03A, 4'hF);
    nop("R3"); nop("R3");
    // R4: DLL on, weak driver
    regWr("R4", 2'b01, 12'h002, 4'hF);
    nop("R4"); nop("R4");
    // R2: deselected and clock-disabled writes
    step("R2", 1, 1, 0, 0, 0, 2'b00, 12'h003, 4'hF);
    step("R2", 0, 0, 0, 0, 0, 2'b00, 12'h003, 4'hF);
    nop("R2");
    // R5: must-be-zero bits in mode write
    regWr("R5", 2'b00, 12'h081, 4'hF);
    regWr("R5", 2'b10, 12'h001, 4'hF);
    regWr("R5", 2'b00, 12'h401, 4'hF);
    // R6: reserved burst codes
    regWr("R6", 2'b00, 12'h000, 4'hF);
    regWr("R6", 2'b00, 12'h004, 4'hF);
    regWr("R6", 2'b00, 12'h007, 4'hF);
    // R7: extended must-be-zero and driver codes
    regWr("R7", 2'b01, 12'h00A, 4'hF);
    regWr("R7", 2'b01, 12'h000, 4'hF);
    regWr("R7", 2'b01, 12'h042, 4'hF);
    regWr("R7", 2'b11, 12'h002, 4'hF);
    // R8: an open bank
    regWr("R8", 2'b00, 12'h001, 4'hB);
    nop("R8");
    // R9: write in busy window while a bank is open: one flag, no window restart
    regWr("R9", 2'b00, 12'h103, 4'hF);
    regWr("R9", 2'b00, 12'h002, 4'h7);
    regWr("R9", 2'b01, 12'h003, 4'hF);
    step("R9", 1, 0, 0, 1, 1, 2'b00, 12'h000, 4'hF);
    nop("R9");
    nop("R9");
    regWr("R9", 2'b00, 12'h022, 4'hF);
    nop("R9");
    step("R9", 1, 0, 1, 0, 1, 2'b00, 12'h000, 4'hF);
    // R11: other commands outside the window
    step("R11", 1, 0, 0, 1, 1, 2'b10, 12'hFFF, 4'h0);
    step("R11", 1, 0, 1, 0, 1, 2'b01, 12'h123, 4'hF);
    step("R11", 1, 0, 0, 1, 0, 2'b00, 12'h400, 4'hF);
    // R10: flag lasts one cycle
    regWr("R10", 2'b00, 12'h080, 4'hF);
    nop("R10");
    nop("R10");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [1:0]  ba;
      logic [3:0]  idle;
      logic [2:0]  cmd;
      a    = 12'($urandom);
      ba   = 2'($urandom);
      idle = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
      cmd  = 3'($urandom);
      if ($urandom % 2 == 0) begin
        ba[1] = 1'b0;
        if (ba[0]) begin a = a & 12'h001; a[1] = 1'b1; end
        else begin a = a & 12'h17F; a[2:0] = 3'(1 + $urandom % 3); end
      end
      if (cmd < 3)       step("RND", 1, 0, 0, 0, 0, ba, a, idle);
      else if (cmd == 3) step("RND", 1, 0, 1, 1, 1, ba, a, idle);
      else if (cmd == 4) step("RND", 1, 1, 0, 0, 0, ba, a, idle);
      else if (cmd == 5) step("RND", 0, 0, 0, 0, 0, ba, a, idle);
      else               step("RND", 1, 0, a[9], a[10], a[11], ba, a, idle);
    end
    nop("END");
    @(negedge clk);
    compareOut();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule